// File: doc/BRIEF.md
# Scanline Sprite Evaluation Unit

This block picks, for one raster line, the sprites that must be drawn on it. A table of 64 sprite descriptors is held outside the block. Each descriptor is 4 bytes wide: vertical position, tile number, attribute byte and horizontal position. On a start pulse the block steps through the table, one descriptor per clock, and compares each vertical position against the line being prepared.

Up to eight matching descriptors are copied, in the order they are found, into a local bank of eight slots. The table index each one came from is stored beside it. A ninth match raises an overflow flag and ends the scan at once. The block also reports how many slots were filled and whether descriptor 0 was among them, which a later hit-detection stage needs.

The scan controller issues the start pulse at the beginning of horizontal blanking on every visible line. A pattern-fetch stage then reads the filled slots through a slot-select port.

Top module: `spr_line_eval`

## Requirements
- R1: After reset, busy, done, the selected count, the overflow flag and the zero flag are all 0, and every slot reads back as 0 with source index 0.
- R2: A start pulse while idle on a line below 240 begins a scan. On the following clocks busy is 1 and desc_idx presents indices 0, 1, 2 … 63 in rising order, one per clock.
- R3: A descriptor matches when the line minus its vertical position (desc_data bits 7:0) is between 0 and height−1. The height is 16 when tall_mode is 1 and 8 otherwise. Line and tall_mode are captured at the start pulse, so later changes have no effect on the scan in progress.
- R4: Matching descriptors fill slots 0, 1, 2 … in the order found. slot_data returns the full 32-bit descriptor of the selected slot, and slot_src returns its table index. Both are combinational from slot_sel.
- R5: sel_count gives the number of slots filled by the latest scan, from 0 to 8.
- R6: A match found while all eight slots are full sets overflow and ends the scan on that descriptor. No slot is written by it.
- R7: zero_hit_ok is 1 after a scan in which descriptor 0 was selected, and 0 otherwise.
- R8: done is a one-clock pulse that comes in the clock after the last descriptor examined. That is descriptor 63, or the overflowing one. busy falls in the same clock.
- R9: A new scan clears sel_count, overflow and zero_hit_ok at its start. Slots at positions at or above the new count keep the contents from earlier scans.
- R10: A start pulse is ignored while a scan is running, and also when the line is 240 or higher. In either case the scan in progress and all results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (one-clock pulse) |
| line_in | input | 8 | Line being prepared |
| tall_mode | input | 1 | 1 selects 16-line sprites, 0 selects 8-line sprites |
| desc_idx | output | 6 | Index of the descriptor being examined |
| desc_data | input | 32 | Descriptor at desc_idx: bits 7:0 vertical position, 15:8 tile, 23:16 attribute, 31:24 horizontal position |
| slot_sel | input | 3 | Slot to read back |
| slot_data | output | 32 | Descriptor stored in the selected slot |
| slot_src | output | 6 | Table index stored in the selected slot |
| sel_count | output | 4 | Number of slots filled by the latest scan |
| overflow | output | 1 | A ninth match was found in the latest scan |
| zero_hit_ok | output | 1 | Descriptor 0 was selected in the latest scan |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-clock pulse at the end of a scan |

## Verification
A wrong index counter shows up at once: desc_idx fails to step by one, and done arrives at the wrong clock. The bench counts the exact number of clocks from start to done for every scan. A faulty range compare or a wrong height selection changes sel_count and the source indices read back after done. That appears within one scan, and overflow rows are placed at both early and final descriptors. Corruption of the slot write position or of the stale-slot retention is seen on the next read-back, because every slot's full descriptor and source index are compared against the table contents.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;
    localparam int ENTRIES   = 64;
    localparam int SLOTS     = 8;
    localparam int LINE_W    = 8;
    localparam int DESC_W    = 32;
    localparam int VIS_LINES = 240;
    localparam int SHORT_H   = 8;
    localparam int TALL_H    = 16;

    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W  = $clog2(SLOTS + 1);

    typedef struct packed {
        logic                busy;
        logic                done;
        logic [IDX_W-1:0]    idx;
        logic [CNT_W-1:0]    count;
        logic                ovf;
        logic                zero;
        logic [LINE_W-1:0]   line;
        logic                tall;
    } scan_state_t;
endpackage

// File: rtl/spr_range_match.sv
module spr_range_match
    import spr_eval_pkg::*;
(
    input  logic [LINE_W-1:0] line_q,
    input  logic              tall_q,
    input  logic [LINE_W-1:0] ypos,
    output logic              hit
);
    localparam int DIFF_W = LINE_W + 1;

    logic [DIFF_W-1:0] diff;
    logic [DIFF_W-1:0] height;

    always_comb begin
        diff   = {1'b0, line_q} - {1'b0, ypos};
        height = tall_q ? DIFF_W'(TALL_H) : DIFF_W'(SHORT_H);
        hit    = !diff[DIFF_W-1] && (diff < height);
    end
endmodule

// File: rtl/spr_slot_bank.sv
module spr_slot_bank
    import spr_eval_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DESC_W-1:0] wr_desc,
    input  logic [IDX_W-1:0]  wr_src,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DESC_W-1:0] rd_desc,
    output logic [IDX_W-1:0]  rd_src
);
    logic [DESC_W-1:0] desc_q [SLOTS];
    logic [IDX_W-1:0]  src_q  [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [DESC_W-1:0] desc_d;
        logic [IDX_W-1:0]  src_d;
        logic              sel;

        always_comb begin
            sel    = wr_en && (wr_slot == SLOT_W'(s));
            desc_d = sel ? wr_desc : desc_q[s];
            src_d  = sel ? wr_src  : src_q[s];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                desc_q[s] <= '0;
                src_q[s]  <= '0;
            end else begin
                desc_q[s] <= desc_d;
                src_q[s]  <= src_d;
            end
        end
    end

    always_comb begin
        rd_desc = desc_q[rd_slot];
        rd_src  = src_q[rd_slot];
    end
endmodule

// File: rtl/spr_scan_ctrl.sv
module spr_scan_ctrl
    import spr_eval_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] line_in,
    input  logic              tall_in,
    input  logic              hit,
    output scan_state_t       st_q,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SLOTS);

    scan_state_t st_d;
    logic        room;

    always_comb begin
        room    = (st_q.count < FULL_CNT);
        wr_en   = st_q.busy && hit && room;
        wr_slot = st_q.count[SLOT_W-1:0];

        st_d      = st_q;
        st_d.done = 1'b0;

        if (!st_q.busy) begin
            if (start && (line_in < LINE_W'(VIS_LINES))) begin
                st_d.busy  = 1'b1;
                st_d.idx   = '0;
                st_d.count = '0;
                st_d.ovf   = 1'b0;
                st_d.zero  = 1'b0;
                st_d.line  = line_in;
                st_d.tall  = tall_in;
            end
        end else begin
            if (hit && room) begin
                st_d.count = st_q.count + 1'b1;
                if (st_q.idx == '0) begin
                    st_d.zero = 1'b1;
                end
            end
            if (hit && !room) begin
                st_d.ovf  = 1'b1;
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spr_line_eval.sv
module spr_line_eval
    import spr_eval_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] line_in,
    input  logic              tall_mode,
    output logic [IDX_W-1:0]  desc_idx,
    input  logic [DESC_W-1:0] desc_data,
    input  logic [SLOT_W-1:0] slot_sel,
    output logic [DESC_W-1:0] slot_data,
    output logic [IDX_W-1:0]  slot_src,
    output logic [CNT_W-1:0]  sel_count,
    output logic              overflow,
    output logic              zero_hit_ok,
    output logic              busy,
    output logic              done
);
    scan_state_t       st_q;
    logic              hit;
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;

    spr_range_match u_match (
        .line_q (st_q.line),
        .tall_q (st_q.tall),
        .ypos   (desc_data[LINE_W-1:0]),
        .hit    (hit)
    );

    spr_scan_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .line_in (line_in),
        .tall_in (tall_mode),
        .hit     (hit),
        .st_q    (st_q),
        .wr_en   (wr_en),
        .wr_slot (wr_slot)
    );

    spr_slot_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_desc (desc_data),
        .wr_src  (st_q.idx),
        .rd_slot (slot_sel),
        .rd_desc (slot_data),
        .rd_src  (slot_src)
    );

    always_comb begin
        desc_idx    = st_q.idx;
        sel_count   = st_q.count;
        overflow    = st_q.ovf;
        zero_hit_ok = st_q.zero;
        busy        = st_q.busy;
        done        = st_q.done;
    end
endmodule

// File: rtl/spr_line_eval_chk.sv
module spr_line_eval_chk
    import spr_eval_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LINE_W-1:0] line_in,
    input logic [IDX_W-1:0]  desc_idx,
    input logic [CNT_W-1:0]  sel_count,
    input logic              overflow,
    input logic              zero_hit_ok,
    input logic              busy,
    input logic              done
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R5
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_count <= CNT_W'(SLOTS));

    // R6
    overflow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (sel_count == CNT_W'(SLOTS)));

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (desc_idx == IDX_W'($past(desc_idx) + 1'b1)));

    // R10
    vis_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (line_in >= LINE_W'(VIS_LINES))) |=> !busy);

    // R7
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_hit_ok) |-> ($past(desc_idx) == '0));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ((sel_count == $past(sel_count)) ||
             (sel_count == CNT_W'($past(sel_count) + 1'b1))));
endmodule

bind spr_line_eval spr_line_eval_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .line_in     (line_in),
    .desc_idx    (desc_idx),
    .sel_count   (sel_count),
    .overflow    (overflow),
    .zero_hit_ok (zero_hit_ok),
    .busy        (busy),
    .done        (done)
);

// File: tb/spr_line_eval_test.sv
module spr_line_eval_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  line_in = '0;
    logic        tall_mode = 1'b0;
    logic [5:0]  desc_idx;
    logic [31:0] desc_data;
    logic [2:0]  slot_sel = '0;
    logic [31:0] slot_data;
    logic [5:0]  slot_src;
    logic [3:0]  sel_count;
    logic        overflow;
    logic        zero_hit_ok;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit scene  = 1'b0;

    always #4 clk = ~clk;

    spr_line_eval uut (
        .clk(clk), .rst_n(rst_n), .start(start), .line_in(line_in),
        .tall_mode(tall_mode), .desc_idx(desc_idx), .desc_data(desc_data),
        .slot_sel(slot_sel), .slot_data(slot_data), .slot_src(slot_src),
        .sel_count(sel_count), .overflow(overflow), .zero_hit_ok(zero_hit_ok),
        .busy(busy), .done(done)
    );

    // scene 0: y = 4*i (sparse); scene 1: y = i (dense)
    function automatic logic [31:0] mk_desc(bit sc, int i);
        logic [7:0] y;
        y = sc ? 8'(i) : 8'(4 * i);
        return {8'(255 - i), 8'(i ^ 8'h5A), 8'(i + 8'h80), y};
    endfunction

    assign desc_data = mk_desc(scene, int'(desc_idx));

    typedef struct packed {
        bit         sc;
        logic [7:0] line;
        bit         tall;
        logic [3:0] cnt;
        bit         ovf;
        bit         zero;
        logic [5:0] first;
        logic [5:0] last;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'd10,  1'b0, 4'd8, 1'b0, 1'b0, 6'd3,  6'd63},
        '{1'b1, 8'd20,  1'b1, 4'd8, 1'b1, 1'b0, 6'd5,  6'd13},
        '{1'b1, 8'd0,   1'b0, 4'd1, 1'b0, 1'b1, 6'd0,  6'd63},
        '{1'b1, 8'd3,   1'b0, 4'd4, 1'b0, 1'b1, 6'd0,  6'd63},
        '{1'b1, 8'd70,  1'b1, 4'd8, 1'b1, 1'b0, 6'd55, 6'd63},
        '{1'b1, 8'd70,  1'b0, 4'd1, 1'b0, 1'b0, 6'd63, 6'd63},
        '{1'b1, 8'd100, 1'b1, 4'd0, 1'b0, 1'b0, 6'd0,  6'd63},
        '{1'b1, 8'd7,   1'b0, 4'd8, 1'b0, 1'b1, 6'd0,  6'd63},
        '{1'b1, 8'd15,  1'b1, 4'd8, 1'b1, 1'b1, 6'd0,  6'd8},
        '{1'b0, 8'd0,   1'b0, 4'd1, 1'b0, 1'b1, 6'd0,  6'd63},
        '{1'b0, 8'd13,  1'b1, 4'd4, 1'b0, 1'b1, 6'd0,  6'd63},
        '{1'b0, 8'd200, 1'b0, 4'd2, 1'b0, 1'b0, 6'd49, 6'd63},
        '{1'b0, 8'd239, 1'b1, 4'd4, 1'b0, 1'b0, 6'd56, 6'd63},
        '{1'b1, 8'd8,   1'b0, 4'd8, 1'b0, 1'b0, 6'd1,  6'd63}
    };

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issues start at a negedge, returns edges from the start edge to done.
    task automatic run_scan(bit sc, logic [7:0] ln, bit tl, output int edges);
        scene     = sc;
        line_in   = ln;
        tall_mode = tl;
        start     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        edges = 0;
        while (!done && edges < 300) begin
            @(posedge clk);
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic check_slots(bit sc, int n, int first, string tag);
        for (int s = 0; s < n; s++) begin
            slot_sel = 3'(s);
            #1;
            chk(slot_src == 6'(first + s), {tag, " src"}, slot_src, first + s);
            chk(slot_data == mk_desc(sc, first + s), {tag, " data"},
                slot_data, mk_desc(sc, first + s));
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        int e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        chk(sel_count == 0 && overflow == 0 && zero_hit_ok == 0, "R1 results",
            {sel_count, overflow, zero_hit_ok}, 0);
        slot_sel = 3'd5;
        #1;
        chk(slot_data == 0 && slot_src == 0, "R1 slot", slot_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6 R7 R8: table walk
        for (int v = 0; v < NV; v++) begin
            run_scan(VECS[v].sc, VECS[v].line, VECS[v].tall, e);
            chk(e == int'(VECS[v].last) + 1, $sformatf("R8 row%0d done timing", v),
                e, int'(VECS[v].last) + 1);
            chk(busy == 1'b0, $sformatf("R8 row%0d busy low", v), busy, 0);
            chk(sel_count == VECS[v].cnt, $sformatf("R5 R3 row%0d count", v),
                sel_count, VECS[v].cnt);
            chk(overflow == VECS[v].ovf, $sformatf("R6 row%0d overflow", v),
                overflow, VECS[v].ovf);
            chk(zero_hit_ok == VECS[v].zero, $sformatf("R7 row%0d zero", v),
                zero_hit_ok, VECS[v].zero);
            check_slots(VECS[v].sc, int'(VECS[v].cnt), int'(VECS[v].first),
                $sformatf("R4 row%0d", v));
            @(negedge clk);
            chk(done == 1'b0, $sformatf("R8 row%0d pulse width", v), done, 0);
        end

        // R9: stale slots survive a shorter scan (previous fill 55..62)
        run_scan(1'b1, 8'd70, 1'b1, e);
        run_scan(1'b1, 8'd70, 1'b0, e);
        chk(sel_count == 1, "R9 count cleared", sel_count, 1);
        slot_sel = 3'd1;
        #1;
        chk(slot_src == 6'd56, "R9 stale slot kept", slot_src, 56);

        // R10: start on a non-visible line is ignored
        @(negedge clk);
        line_in = 8'd240;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R10 line 240 ignored", busy, 0);
        repeat (70) @(negedge clk);
        chk(sel_count == 1 && done == 0, "R10 results unchanged", sel_count, 1);

        // R10 R3: start and line changes during a scan have no effect
        scene     = 1'b1;
        line_in   = 8'd10;
        tall_mode = 1'b0;
        start     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        e = 0;
        repeat (20) begin
            @(posedge clk);
            @(negedge clk);
            e++;
        end
        line_in   = 8'd200;
        tall_mode = 1'b1;
        start     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        e++;
        start = 1'b0;
        while (!done && e < 300) begin
            @(posedge clk);
            @(negedge clk);
            e++;
        end
        chk(e == 64, "R10 restart ignored timing", e, 64);
        chk(sel_count == 8 && overflow == 0, "R3 captured line count", sel_count, 8);
        check_slots(1'b1, 8, 3, "R3 captured line");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule